// File: doc/BRIEF.md
# Pipelined Radix-8 Unsigned Divider

This block divides a 32-bit unsigned dividend by a 32-bit unsigned divisor and returns the quotient and remainder. Each arithmetic step retires one base-8 quotient digit, so three quotient bits per step. The dividend is zero-extended to 33 bits so that eleven digits cover it exactly. An entry register performs this widening. A chain of eleven digit steps follows. The result is taken from the last register in the chain.

The block has two timing modes. In normal mode, two digit steps share one register stage. This gives six digit stages and seven cycles of latency. In fast mode, a register follows every step. This gives eleven digit stages and twelve cycles of latency, and each stage has half the logic depth. The mode is taken from a static input. It is captured only while no operation is in flight.

One operation can enter on every cycle. Each operation carries a tag. Results leave in issue order with the same tag. The block has no backpressure.

Top module: `radix8_div`

## Requirements
- R1: For a nonzero divisor, `quotient_o` equals dividend / divisor and `remainder_o` equals dividend % divisor, with both operands taken as 32-bit unsigned values. The remainder is always smaller than the divisor.
- R2: With the normal mode in effect (`fast_mode_i` = 0), an operation accepted at a rising edge E appears with `out_valid_o` high just after edge E+6, which is 7 cycles of latency.
- R3: With the fast mode in effect (`fast_mode_i` = 1), an operation accepted at edge E appears just after edge E+11, which is 12 cycles of latency.
- R4: An operation is accepted on every edge where `in_valid_i` is high. Results leave in acceptance order, each with the `in_tag_i` it was accepted with. `out_valid_o` is never high without a matching accepted operation.
- R5: A divisor of zero gives a quotient of all ones and a remainder equal to the dividend, with the same latency as a normal operation in the current mode.
- R6: `fast_mode_i` is sampled only at edges where no pipeline stage holds a valid operation. An operation accepted at such an edge uses the newly sampled mode. A change requested while any stage is busy has no effect on the operations in flight and takes hold only once the pipeline has drained.
- R7: Asserting `rst_ni` low clears every stage valid bit at once. No operation that was in flight before the reset ever appears on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fast_mode_i | input | 1 | 1 places a register after every digit step |
| in_valid_i | input | 1 | Operation present on the input |
| dividend_i | input | DATA_W | Unsigned dividend |
| divisor_i | input | DATA_W | Unsigned divisor |
| in_tag_i | input | TAG_W | Tag carried with the operation |
| out_valid_o | output | 1 | Result present on the output |
| quotient_o | output | DATA_W | Quotient |
| remainder_o | output | DATA_W | Remainder |
| out_tag_o | output | TAG_W | Tag of the result |

## Verification
The bench builds the block with its defaults: DATA_W = 32 and TAG_W = 4. With these values there are eleven digit steps with an odd step left at the end. The last step therefore stands alone in normal mode. This makes both the 7-cycle and 12-cycle latencies, and the unpaired final stage, reachable.

The 32-bit width puts the extreme operands within reach. These include an all-ones dividend, an all-ones divisor and a zero divisor. It also covers the padding digit above bit 31, which has to resolve to zero.

The 4-bit tag wraps during back-to-back bursts. This exercises the ordering check against reused tag values.

// File: rtl/radix8_div_pkg.sv
package radix8_div_pkg;
  localparam int unsigned DIGIT_W = 3;

  // digits needed to cover a zero-extended operand of width w
  function automatic int unsigned num_steps(int unsigned w);
    return (w + 1 + DIGIT_W - 1) / DIGIT_W;
  endfunction
endpackage

// File: rtl/radix8_div_step.sv
module radix8_div_step
  import radix8_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAD_W  = 33,
  parameter int unsigned REM_W  = 35
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [PAD_W-1:0]  dq_i,
  input  logic [DATA_W-1:0] dsr_i,
  output logic [REM_W-1:0]  rem_o,
  output logic [PAD_W-1:0]  dq_o
);
  localparam int unsigned RADIX = 1 << DIGIT_W;

  logic [REM_W-1:0]   rem_sh;
  logic [DIGIT_W-1:0] digit;

  // restoring digit selection: largest multiple not above the shifted remainder
  always_comb begin
    rem_sh = {rem_i[REM_W-DIGIT_W-1:0], dq_i[PAD_W-1 -: DIGIT_W]};
    digit  = '0;
    rem_o  = rem_sh;
    for (int k = 1; k < RADIX; k++) begin
      logic [REM_W-1:0] mult;
      mult = REM_W'(dsr_i) * REM_W'(k);
      if (mult <= rem_sh) begin
        digit = DIGIT_W'(k);
        rem_o = rem_sh - mult;
      end
    end
  end

  // quotient digits enter where dividend digits leave
  assign dq_o = {dq_i[PAD_W-DIGIT_W-1:0], digit};
endmodule

// File: rtl/radix8_div_slot.sv
module radix8_div_slot #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned PAD_W  = 33,
  parameter int unsigned REM_W  = 35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              valid_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic [PAD_W-1:0]  dq_i,
  input  logic [DATA_W-1:0] dsr_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              reg_valid_o,
  output logic              valid_o,
  output logic [REM_W-1:0]  rem_o,
  output logic [PAD_W-1:0]  dq_o,
  output logic [DATA_W-1:0] dsr_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [REM_W-1:0]  rem_s, rem_q;
  logic [PAD_W-1:0]  dq_s, dq_q;
  logic [DATA_W-1:0] dsr_q;
  logic [TAG_W-1:0]  tag_q;
  logic              v_q;

  radix8_div_step #(.DATA_W(DATA_W), .PAD_W(PAD_W), .REM_W(REM_W)) u_step (
    .rem_i (rem_i),
    .dq_i  (dq_i),
    .dsr_i (dsr_i),
    .rem_o (rem_s),
    .dq_o  (dq_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= 1'b0;
    else         v_q <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    rem_q <= rem_s;
    dq_q  <= dq_s;
    dsr_q <= dsr_i;
    tag_q <= tag_i;
  end

  assign reg_valid_o = v_q;
  assign valid_o     = bypass_i ? valid_i : v_q;
  assign rem_o       = bypass_i ? rem_s   : rem_q;
  assign dq_o        = bypass_i ? dq_s    : dq_q;
  assign dsr_o       = bypass_i ? dsr_i   : dsr_q;
  assign tag_o       = bypass_i ? tag_i   : tag_q;
endmodule

// File: rtl/radix8_div.sv
module radix8_div
  import radix8_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_mode_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] quotient_o,
  output logic [DATA_W-1:0] remainder_o,
  output logic [TAG_W-1:0]  out_tag_o
);
  localparam int unsigned STEPS = num_steps(DATA_W);
  localparam int unsigned PAD_W = STEPS * DIGIT_W;
  localparam int unsigned REM_W = DATA_W + DIGIT_W;

  logic              fast_q;
  logic              busy;
  logic [STEPS-1:0]  reg_valid;

  logic              v_c   [STEPS+1];
  logic [REM_W-1:0]  rem_c [STEPS+1];
  logic [PAD_W-1:0]  dq_c  [STEPS+1];
  logic [DATA_W-1:0] dsr_c [STEPS+1];
  logic [TAG_W-1:0]  tag_c [STEPS+1];

  // entry stage: widen the dividend to a whole number of digits
  logic              ent_v_q;
  logic [PAD_W-1:0]  ent_dq_q;
  logic [DATA_W-1:0] ent_dsr_q;
  logic [TAG_W-1:0]  ent_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_v_q <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      ent_v_q <= in_valid_i;
      if (!busy) fast_q <= fast_mode_i;
    end
  end

  always_ff @(posedge clk_i) begin
    ent_dq_q  <= PAD_W'(dividend_i);
    ent_dsr_q <= divisor_i;
    ent_tag_q <= in_tag_i;
  end

  assign busy = ent_v_q | (|reg_valid);

  assign v_c[0]   = ent_v_q;
  assign rem_c[0] = '0;
  assign dq_c[0]  = ent_dq_q;
  assign dsr_c[0] = ent_dsr_q;
  assign tag_c[0] = ent_tag_q;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    // first step of a pair skips its register in normal mode
    localparam bit PAIR_HEAD = (s % 2 == 0) && (s != STEPS - 1);
    logic bypass;
    assign bypass = PAIR_HEAD && !fast_q;

    radix8_div_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .PAD_W(PAD_W), .REM_W(REM_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bypass_i    (bypass),
      .valid_i     (v_c[s]),
      .rem_i       (rem_c[s]),
      .dq_i        (dq_c[s]),
      .dsr_i       (dsr_c[s]),
      .tag_i       (tag_c[s]),
      .reg_valid_o (reg_valid[s]),
      .valid_o     (v_c[s+1]),
      .rem_o       (rem_c[s+1]),
      .dq_o        (dq_c[s+1]),
      .dsr_o       (dsr_c[s+1]),
      .tag_o       (tag_c[s+1])
    );
  end

  // exit: truncate to the operand width
  assign out_valid_o = v_c[STEPS];
  assign quotient_o  = dq_c[STEPS][DATA_W-1:0];
  assign remainder_o = rem_c[STEPS][DATA_W-1:0];
  assign out_tag_o   = tag_c[STEPS];
endmodule

// File: rtl/radix8_div_chk.sv
module radix8_div_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAD_W  = 33,
  parameter int unsigned REM_W  = 35
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fast_q_i,
  input logic              busy_i,
  input logic              in_valid_i,
  input logic              out_valid_i,
  input logic [DATA_W-1:0] quotient_i,
  input logic [PAD_W-1:0]  q_full_i,
  input logic [REM_W-1:0]  rem_full_i,
  input logic [DATA_W-1:0] dsr_i
);
  logic [7:0] pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= '0;
    else         pend <= pend + 8'(in_valid_i) - 8'(out_valid_i);
  end

  // R6
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(fast_q_i));

  // R1
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && dsr_i != '0) |-> (rem_full_i < REM_W'(dsr_i)));

  // R1
  top_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && dsr_i != '0) |-> (q_full_i[PAD_W-1:DATA_W] == '0));

  // R5
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_i && dsr_i == '0) |-> (quotient_i == '1));

  // R4
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> (pend != '0));

  // R7
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_clear_chk: assert (!out_valid_i);
    end
  end
endmodule

bind radix8_div radix8_div_chk #(.DATA_W(DATA_W), .PAD_W(PAD_W), .REM_W(REM_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fast_q_i    (fast_q),
  .busy_i      (busy),
  .in_valid_i  (in_valid_i),
  .out_valid_i (out_valid_o),
  .quotient_i  (quotient_o),
  .q_full_i    (dq_c[STEPS]),
  .rem_full_i  (rem_c[STEPS]),
  .dsr_i       (dsr_c[STEPS])
);

// File: tb/radix8_div_tb.sv
module radix8_div_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAG_W  = 4;
  localparam int LAT_NORM = 7;
  localparam int LAT_FAST = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fast_mode = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] dividend = '0;
  logic [DATA_W-1:0] divisor = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic              out_valid;
  logic [DATA_W-1:0] quotient, remainder;
  logic [TAG_W-1:0]  out_tag;

  radix8_div #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fast_mode_i (fast_mode),
    .in_valid_i  (in_valid),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .in_tag_i    (in_tag),
    .out_valid_o (out_valid),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .out_tag_o   (out_tag)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int                due;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] r;
    logic [TAG_W-1:0]  tag;
    string             req;
  } exp_t;

  exp_t expq[$];
  int n_chk = 0;
  int n_bad = 0;
  int cur_lat = LAT_NORM;
  logic [TAG_W-1:0] tag_ctr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // output monitor: every expected result at its exact cycle, nothing else
  always @(negedge clk) begin
    if (rst_n) begin
      if (expq.size() > 0 && expq[0].due == cyc) begin
        chk(out_valid == 1'b1, expq[0].req, "out_valid at due cycle", 64'(out_valid), 64'd1);
        if (out_valid) begin
          chk(quotient == expq[0].q, expq[0].req, "quotient", 64'(quotient), 64'(expq[0].q));
          chk(remainder == expq[0].r, expq[0].req, "remainder", 64'(remainder), 64'(expq[0].r));
          chk(out_tag == expq[0].tag, "R4", "tag order", 64'(out_tag), 64'(expq[0].tag));
        end
        void'(expq.pop_front());
      end else if (out_valid) begin
        chk(1'b0, "R4", "out_valid without pending result", 64'(out_valid), 64'd0);
      end
    end
  end

  // drive one operation at a negedge; it is accepted at the next edge
  task automatic issue(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] d,
                       input int lat, input string req);
    exp_t e;
    in_valid = 1'b1;
    dividend = a;
    divisor  = d;
    in_tag   = tag_ctr;
    e.due = cyc + lat;
    e.q   = (d == 0) ? '1 : a / d;
    e.r   = (d == 0) ? a  : a % d;
    e.tag = tag_ctr;
    e.req = req;
    expq.push_back(e);
    tag_ctr++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 40 && expq.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, req, "all results delivered", 64'(expq.size()), 64'd0);
  endtask

  task automatic set_mode(input bit m);
    fast_mode = m;
    repeat (4) @(negedge clk);
    cur_lat = m ? LAT_FAST : LAT_NORM;
  endtask

  task automatic t_reset_state();
    chk(out_valid == 1'b0, "R7", "out_valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_directed(input string req);
    issue(32'd100, 32'd7, cur_lat, req);
    repeat (2) @(negedge clk);
    issue(32'd0, 32'd5, cur_lat, req);
    issue(32'hFFFF_FFFF, 32'd1, cur_lat, req);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, cur_lat, req);
    issue(32'd5, 32'hFFFF_FFFF, cur_lat, req);
    issue(32'h1234_5678, 32'd3, cur_lat, req);
    issue(32'h8000_0000, 32'h0000_0007, cur_lat, req);
    issue(32'hDEAD_BEEF, 32'h0001_0000, cur_lat, req);
    drain(req);
  endtask

  task automatic t_burst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] a, d;
      a = $urandom;
      d = (i % 3 == 0) ? ($urandom >> ($urandom % 32)) : $urandom;
      if (d == 0) d = 1;
      issue(a, d, cur_lat, req);
    end
    drain(req);
  endtask

  task automatic t_divzero();
    issue(32'h0000_0000, 32'd0, cur_lat, "R5");
    issue(32'hCAFE_F00D, 32'd0, cur_lat, "R5");
    issue(32'd9, 32'd3, cur_lat, "R5");
    drain("R5");
  endtask

  task automatic t_switch();
    fast_mode = 1'b0;
    repeat (4) @(negedge clk);
    issue(32'd1000, 32'd9, LAT_NORM, "R6");
    fast_mode = 1'b1; // requested while busy: ignored for ops in flight
    issue(32'd999, 32'd10, LAT_NORM, "R6");
    issue(32'd77, 32'd0, LAT_NORM, "R6");
    drain("R6");
    repeat (2) @(negedge clk);
    issue(32'd1001, 32'd11, LAT_FAST, "R6");
    fast_mode = 1'b0; // busy again in fast mode
    issue(32'd4096, 32'd8, LAT_FAST, "R6");
    drain("R6");
    repeat (2) @(negedge clk);
    issue(32'd4097, 32'd8, LAT_NORM, "R6");
    drain("R6");
    cur_lat = LAT_NORM;
  endtask

  task automatic t_reset_flight();
    issue(32'd50, 32'd5, cur_lat, "R7");
    issue(32'd51, 32'd5, cur_lat, "R7");
    issue(32'd52, 32'd5, cur_lat, "R7");
    rst_n = 1'b0;
    expq.delete();
    chk(out_valid == 1'b0, "R7", "out_valid in reset", 64'(out_valid), 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (16) @(negedge clk);
    chk(expq.size() == 0, "R7", "no stale result", 64'(expq.size()), 64'd0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    set_mode(1'b0);
    t_directed("R1 R2");
    t_burst(24, "R4 R2");
    t_divzero();
    set_mode(1'b1);
    t_directed("R1 R3");
    t_burst(24, "R4 R3");
    t_divzero();
    t_switch();
    t_burst(40, "R1");
    t_reset_flight();
    set_mode(1'b1);
    t_reset_flight();
    set_mode(1'b0);
    t_burst(8, "R7");
    finish_run();
  end
endmodule